// File: doc/BRIEF.md
# Eight-pixel Colour Compare Unit

This unit classifies the eight pixels of one byte column of a planar frame buffer against a small table of reference colours. Software fills up to eight reference slots. Each slot holds a 3-bit colour and a flag that takes the slot out of use. A start strobe with a byte address makes the unit fetch that byte from the blue, red and green planes. It builds the colour of each pixel from the three plane bits and walks the pixels from the leftmost to the rightmost. For each pixel it records whether the colour equals any reference that is in use.

A plane-disable input removes chosen colour planes from the comparison. Its inverted low three bits mask both the pixel colour and every reference before they are compared. The result is an 8-bit status byte, one bit per pixel, which the processor can read but not write. A one-cycle done pulse marks the point where the status byte is final.

Top module: `ccu_colour_compare`

## Requirements
- R1: After reset every reference slot holds 0x80 and is therefore out of use, the status byte is 0x00, and `done_o` and `mem_req_o` are low.
- R2: When a start is accepted, the unit raises `mem_req_o` on the three following cycles with `mem_plane_o` = 0, 1, 2 in that order and `mem_addr_o` equal to the latched address. The memory returns the data in the cycle after each request.
- R3: Plane 0 is blue, plane 1 is red and plane 2 is green. A pixel's colour has blue in bit 0, red in bit 1 and green in bit 2.
- R4: The pixel colour and each reference colour (bits 2:0 of the slot) are ANDed with the inverse of `plane_off_i[2:0]` before comparison. `plane_off_i` is sampled when the start is accepted.
- R5: A pixel's status bit is 1 when its masked colour equals the masked colour of at least one slot whose bit 7 is 0. A slot with bit 7 set never matches.
- R6: When no slot is in use, the status byte ends as 0x00.
- R7: Pixels are evaluated from byte bit 7 down to bit 0, one per cycle. Each result is shifted into the status byte from the right, so the result for byte bit n ends in status bit n.
- R8: The status byte is cleared in the cycle after a start is accepted. While the unit is idle it holds its value.
- R9: `done_o` is high for exactly one cycle, the 13th cycle after the start was accepted, one cycle after the last pixel result is stored.
- R10: A start while a compare is in progress is ignored: no new reads are issued and the running result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_we_i | input | 1 | Write strobe for a reference slot |
| ref_idx_i | input | 3 | Reference slot index |
| ref_data_i | input | 8 | Slot value: bit 7 = out of use, bits 2:0 = colour |
| plane_off_i | input | 3 | Plane-disable mask (bit set = plane ignored) |
| start_i | input | 1 | Start a compare |
| addr_i | input | 14 | Byte address to compare |
| mem_req_o | output | 1 | Frame buffer read request |
| mem_plane_o | output | 2 | Plane being read |
| mem_addr_o | output | 14 | Byte address being read |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the request |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 8 | Match status, one bit per pixel |

## Verification
The compare runs over plane data whose colours differ between pixel groups. It runs once with a single blue-only reference, which shows whether the planes are assembled in the right bit positions. It runs once with several references including a disabled one, which separates "any valid slot matches" from "slot index matches" and shows that the disable flag is honoured. A run with the red plane disabled merges colours that differ only in red. A single green pixel at byte bit 0 exposes a reversed scan order. Empty-table runs and a start strobe issued during a busy compare show that the status byte drops to zero and that the running compare ignores the new start. A behavioural model compares the outputs on every clock.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_DRAIN,
    ST_EVAL
  } ccu_state_e;
endpackage

// File: rtl/ccu_ref_bank.sv
module ccu_ref_bank #(
  parameter int NUM_REFS = 8,
  parameter int DW       = 8,
  parameter int CW       = 3,
  localparam int IW      = $clog2(NUM_REFS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [IW-1:0]                idx_i,
  input  logic [DW-1:0]                data_i,
  output logic [NUM_REFS-1:0]          valid_o,
  output logic [NUM_REFS-1:0][CW-1:0]  col_o
);
  // only the disable flag (MSB) and the colour field are stored
  logic unused_data_bits;
  assign unused_data_bits = ^data_i[DW-2:CW];

  for (genvar i = 0; i < NUM_REFS; i++) begin : g_slot
    logic          off_q;
    logic [CW-1:0] col_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        off_q <= 1'b1;
        col_q <= '0;
      end else if (we_i && idx_i == IW'(i)) begin
        off_q <= data_i[DW-1];
        col_q <= data_i[CW-1:0];
      end
    end
    assign valid_o[i] = ~off_q;
    assign col_o[i]   = col_q;
  end
endmodule

// File: rtl/ccu_pixel_match.sv
module ccu_pixel_match #(
  parameter int NUM_REFS = 8,
  parameter int CW       = 3
) (
  input  logic [CW-1:0]                col_i,
  input  logic [CW-1:0]                en_i,
  input  logic [NUM_REFS-1:0]          valid_i,
  input  logic [NUM_REFS-1:0][CW-1:0]  ref_i,
  output logic                         hit_o
);
  logic [NUM_REFS-1:0] eq;
  for (genvar i = 0; i < NUM_REFS; i++) begin : g_cmp
    assign eq[i] = valid_i[i] && ((ref_i[i] & en_i) == (col_i & en_i));
  end
  assign hit_o = |eq;
endmodule

// File: rtl/ccu_seq.sv
module ccu_seq
  import ccu_pkg::*;
#(
  parameter int NPLANES = 3,
  parameter int PIX     = 8,
  localparam int PLW    = $clog2(NPLANES),
  localparam int CW     = $clog2(PIX > NPLANES ? PIX : NPLANES)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  output logic           accept_o,
  output logic           busy_o,
  output logic           req_o,
  output logic [PLW-1:0] plane_o,
  output logic           cap_o,
  output logic [PLW-1:0] cap_plane_o,
  output logic           eval_o,
  output logic [CW-1:0]  pix_o,
  output logic           done_o
);
  localparam logic [CW-1:0] LAST_PL  = CW'(NPLANES - 1);
  localparam logic [CW-1:0] FIRST_PX = CW'(PIX - 1);

  ccu_state_e     state_q;
  logic [CW-1:0]  cnt_q;
  logic           cap_q;
  logic [PLW-1:0] cap_pl_q;
  logic           done_q;

  assign accept_o = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_READ;
          cnt_q   <= '0;
        end
        ST_READ: if (cnt_q == LAST_PL) begin
          state_q <= ST_DRAIN;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        ST_DRAIN: begin
          state_q <= ST_EVAL;
          cnt_q   <= FIRST_PX;
        end
        ST_EVAL: if (cnt_q == '0) begin
          state_q <= ST_IDLE;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // read data returns one cycle after the request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q    <= 1'b0;
      cap_pl_q <= '0;
      done_q   <= 1'b0;
    end else begin
      cap_q    <= (state_q == ST_READ);
      cap_pl_q <= cnt_q[PLW-1:0];
      done_q   <= (state_q == ST_EVAL) && (cnt_q == '0);
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign req_o       = (state_q == ST_READ);
  assign plane_o     = cnt_q[PLW-1:0];
  assign cap_o       = cap_q;
  assign cap_plane_o = cap_pl_q;
  assign eval_o      = (state_q == ST_EVAL);
  assign pix_o       = cnt_q;
  assign done_o      = done_q;
endmodule

// File: rtl/ccu_colour_compare.sv
module ccu_colour_compare #(
  parameter int NUM_REFS = 8,
  parameter int PIX      = 8,
  parameter int NPLANES  = 3,
  parameter int AW       = 14,
  localparam int IW      = $clog2(NUM_REFS),
  localparam int PLW     = $clog2(NPLANES),
  localparam int CW      = $clog2(PIX > NPLANES ? PIX : NPLANES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ref_we_i,
  input  logic [IW-1:0]      ref_idx_i,
  input  logic [PIX-1:0]     ref_data_i,
  input  logic [NPLANES-1:0] plane_off_i,
  input  logic               start_i,
  input  logic [AW-1:0]      addr_i,
  output logic               mem_req_o,
  output logic [PLW-1:0]     mem_plane_o,
  output logic [AW-1:0]      mem_addr_o,
  input  logic [PIX-1:0]     mem_rdata_i,
  output logic               done_o,
  output logic [PIX-1:0]     status_o
);
  logic                              accept, busy, cap, eval, hit;
  logic [PLW-1:0]                    cap_plane;
  logic [CW-1:0]                     pix;
  logic [NUM_REFS-1:0]               ref_valid;
  logic [NUM_REFS-1:0][NPLANES-1:0]  ref_col;
  logic [AW-1:0]                     addr_q;
  logic [NPLANES-1:0]                off_q;
  logic [NPLANES-1:0]                pix_col;
  logic [PIX-1:0]                    status_q;

  ccu_ref_bank #(.NUM_REFS(NUM_REFS), .DW(PIX), .CW(NPLANES)) u_refs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ref_we_i),
    .idx_i   (ref_idx_i),
    .data_i  (ref_data_i),
    .valid_o (ref_valid),
    .col_o   (ref_col)
  );

  ccu_seq #(.NPLANES(NPLANES), .PIX(PIX)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .accept_o    (accept),
    .busy_o      (busy),
    .req_o       (mem_req_o),
    .plane_o     (mem_plane_o),
    .cap_o       (cap),
    .cap_plane_o (cap_plane),
    .eval_o      (eval),
    .pix_o       (pix),
    .done_o      (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      off_q  <= '0;
    end else if (accept) begin
      addr_q <= addr_i;
      off_q  <= plane_off_i;
    end
  end
  assign mem_addr_o = addr_q;

  // per-plane byte capture; colour bit p comes from plane p
  for (genvar p = 0; p < NPLANES; p++) begin : g_plane
    logic [PIX-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                byte_q <= '0;
      else if (cap && cap_plane == PLW'(p))       byte_q <= mem_rdata_i;
    end
    assign pix_col[p] = byte_q[pix];
  end

  ccu_pixel_match #(.NUM_REFS(NUM_REFS), .CW(NPLANES)) u_match (
    .col_i   (pix_col),
    .en_i    (~off_q),
    .valid_i (ref_valid),
    .ref_i   (ref_col),
    .hit_o   (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      status_q <= '0;
    else if (accept)  status_q <= '0;
    else if (eval)    status_q <= {status_q[PIX-2:0], hit};
  end
  assign status_o = status_q;
endmodule

// File: rtl/ccu_checker.sv
module ccu_checker #(
  parameter int PIX     = 8,
  parameter int NPLANES = 3,
  localparam int PLW    = $clog2(NPLANES)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           busy_i,
  input logic           eval_i,
  input logic           mem_req_i,
  input logic [PLW-1:0] mem_plane_i,
  input logic           done_i,
  input logic [PIX-1:0] status_i
);
  assert_read_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && mem_plane_i == '0) |=> (mem_req_i && mem_plane_i == PLW'(1)));

  assert_shift_in_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_i |=> (status_i[PIX-1:1] == $past(status_i[PIX-2:0])));

  assert_clear_on_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i) |=> (status_i == '0));

  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !start_i) |=> $stable(status_i));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (!busy_i && !mem_req_i));

  assert_ignore_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && eval_i) |=> !mem_req_i);
endmodule

bind ccu_colour_compare ccu_checker #(.PIX(PIX), .NPLANES(NPLANES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_i      (busy),
  .eval_i      (eval),
  .mem_req_i   (mem_req_o),
  .mem_plane_i (mem_plane_o),
  .done_i      (done_o),
  .status_i    (status_o)
);

// File: tb/ccu_colour_compare_bench.sv
`timescale 1ns/1ps
module ccu_colour_compare_bench;
  localparam int AW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_we = 1'b0;
  logic [2:0]    ref_idx = '0;
  logic [7:0]    ref_data = '0;
  logic [2:0]    plane_off = '0;
  logic          start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          mem_req;
  logic [1:0]    mem_plane;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata = '0;
  logic          done;
  logic [7:0]    status;

  always #2.5 clk = ~clk;

  ccu_colour_compare u_ccu_colour_compare (
    .clk_i(clk), .rst_ni(rst_n), .ref_we_i(ref_we), .ref_idx_i(ref_idx),
    .ref_data_i(ref_data), .plane_off_i(plane_off), .start_i(start),
    .addr_i(addr), .mem_req_o(mem_req), .mem_plane_o(mem_plane),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .done_o(done),
    .status_o(status)
  );

  // plane 0 blue, 1 red, 2 green
  logic [7:0] mem [3][64];
  always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_plane][mem_addr[5:0]];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural model
  logic [7:0]    m_ref [8];
  bit            m_busy = 0;
  bit            m_done = 0;
  int            m_cnt = 0;
  logic [7:0]    m_full = '0;
  logic [7:0]    m_status = '0;
  logic [AW-1:0] m_addr = '0;

  function automatic logic [7:0] calc(input logic [AW-1:0] a, input logic [2:0] off);
    logic [7:0] res = '0;
    for (int px = 7; px >= 0; px--) begin
      logic [2:0] c;
      logic [2:0] en;
      bit h = 0;
      en = ~off;
      c = {mem[2][a[5:0]][px], mem[1][a[5:0]][px], mem[0][a[5:0]][px]};
      for (int r = 0; r < 8; r++)
        if (!m_ref[r][7] && ((m_ref[r][2:0] & en) == (c & en))) h = 1;
      res[px] = h;
    end
    return res;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < 8; r++) m_ref[r] = 8'h80;
      m_busy = 0; m_done = 0; m_cnt = 0; m_status = '0;
    end else begin
      m_done = 0;
      if (!m_busy && start) begin
        m_busy = 1; m_cnt = 0; m_status = '0; m_addr = addr;
        m_full = calc(addr, plane_off);
      end else if (m_busy) begin
        m_cnt++;
        if (m_cnt >= 5) m_status = m_full >> (12 - m_cnt);
        if (m_cnt == 12) begin m_busy = 0; m_done = 1; end
      end
      if (ref_we) m_ref[ref_idx] = ref_data;
    end
  end

  bit run_cmp = 0;
  always @(negedge clk) begin
    if (run_cmp && rst_n) begin
      bit exp_req;
      exp_req = m_busy && m_cnt <= 2;
      chk(done == m_done, "R9 done timing", done, m_done);
      chk(status == m_status, "R7 status per cycle", status, m_status);
      chk(mem_req == exp_req, "R2 request", mem_req, exp_req);
      if (exp_req) begin
        chk(mem_plane == 2'(m_cnt), "R2 plane order", mem_plane, m_cnt);
        chk(mem_addr == m_addr, "R2 address", mem_addr, m_addr);
      end
    end
  end

  task automatic wr_ref(input int idx, input logic [7:0] d);
    @(negedge clk);
    ref_we = 1; ref_idx = 3'(idx); ref_data = d;
    @(negedge clk);
    ref_we = 0;
  endtask

  task automatic set_mem(input int a, input logic [7:0] b, input logic [7:0] r, input logic [7:0] g);
    mem[0][a] = b; mem[1][a] = r; mem[2][a] = g;
  endtask

  task automatic run(input int a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    start = 1; addr = AW'(a);
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 40 && !done; i++) @(negedge clk);
    chk(done == 1'b1, tag, done, 1);
    chk(status == exp, tag, status, exp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int a = 0; a < 64; a++) set_mem(a, 8'h00, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    chk(done == 0 && mem_req == 0, "R1 outputs in reset", {done, mem_req}, 0);
    chk(status == 8'h00, "R1 status in reset", status, 0);
    rst_n = 1;
    run_cmp = 1;
    @(negedge clk);

    // R1/R6: reset table is empty
    set_mem(1, 8'hFF, 8'h0F, 8'h33);
    run(1, 8'h00, "R1 R6 empty table after reset");

    // R3: blue-only reference
    set_mem(5, 8'hF0, 8'h30, 8'h00);
    wr_ref(0, 8'h01);
    run(5, 8'hC0, "R3 blue in bit0");

    // R5: several valid refs, one disabled
    wr_ref(0, 8'h81);
    wr_ref(2, 8'h03);
    wr_ref(5, 8'h00);
    run(5, 8'h3F, "R5 any valid slot, disabled slot ignored");

    // R4: red plane disabled merges 001 and 011
    plane_off = 3'b010;
    run(5, 8'hFF, "R4 red plane masked");
    plane_off = 3'b000;

    // R7: single green pixel at byte bit 0
    wr_ref(2, 8'h80);
    wr_ref(5, 8'h80);
    wr_ref(1, 8'h04);
    set_mem(9, 8'h00, 8'h00, 8'h01);
    run(9, 8'h01, "R7 bit0 pixel lands in status bit0");
    set_mem(10, 8'h00, 8'h00, 8'h80);
    run(10, 8'h80, "R7 bit7 pixel lands in status bit7");

    // R8: status holds while idle
    repeat (6) @(negedge clk);
    chk(status == 8'h80, "R8 hold while idle", status, 8'h80);

    // R10: start during busy ignored
    @(negedge clk);
    start = 1; addr = AW'(9);
    @(negedge clk);
    start = 0;
    repeat (5) @(negedge clk);
    start = 1; addr = AW'(10);
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 40 && !done; i++) @(negedge clk);
    chk(status == 8'h01, "R10 busy start ignored", status, 8'h01);
    begin
      int reqs = 0;
      for (int i = 0; i < 15; i++) begin
        @(negedge clk);
        if (mem_req) reqs++;
      end
      chk(reqs == 0, "R10 no extra reads", reqs, 0);
    end

    // R6: table emptied again
    wr_ref(1, 8'h84);
    run(9, 8'h00, "R6 no valid slot gives zero");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule